// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash model. Every bus write (address, data, write strobe) is fed to a state machine that recognises the two-write unlock prefix and the command bytes behind it. Program, chip erase and block erase are recognised, and a block erase can gather further blocks. The decoder tells the read path whether reads should return array contents or the status byte. It fires single-cycle start pulses, together with a target address, data and a block bitmap, at an external program/erase engine. When the engine reports completion it goes back to array reads, or it holds a failure indication.

States: `ST_ARRAY` (idle, array reads), `ST_UNLK1` (first unlock write seen), `ST_UNLK2` (prefix complete, command expected), `ST_PGM_DATA` (waiting for the address/data write), `ST_ERS_ARM` (erase setup seen, second prefix expected), `ST_ERS_UNLK1`, `ST_ERS_UNLK2` (erase prefix complete, chip or block byte expected), `ST_BLK_COLLECT` (gathering blocks while the window timer runs), `ST_BUSY` (engine running), `ST_FAIL` (engine reported an error). Transitions:
- advance along the prefix on a matching write.
- drop back to `ST_ARRAY` on any mismatch or reset byte.
- launch from `ST_PGM_DATA`, from `ST_ERS_UNLK2` (chip) or from `ST_BLK_COLLECT` when the timer expires.
- leave `ST_BUSY` on engine done, to `ST_ARRAY` or `ST_FAIL`.
- leave `ST_FAIL` on a reset byte.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the decoder is in array-read mode. `read_status`, `pgm_start`, `erase_start` and `status_bits` are all 0.
- R2: The unlock prefix is compared only on address bits [11:0]. In word mode (`byte_mode`=0) the prefix is AAh at 555h then 55h at 2AAh. In byte mode it is AAh at AAAh then 55h at 555h. Command bytes (A0h, 80h, 10h) must be written at the first unlock address of the active mode.
- R3: A program is four writes: unlock prefix, A0h, then a write at any address. The fourth write makes `pgm_start` high for exactly one cycle, starting on the edge that captured it. At the same time `op_addr`/`op_data` show that write's address and data.
- R4: A chip erase is six writes: prefix, 80h, prefix, then 10h at the first unlock address (555h in word mode). The sixth write makes `erase_start` and `erase_all` high in the following cycle.
- R5: A block erase whose sixth write is 30h at any address selects the block given by the top log2(NUM_BLOCKS) address bits. From that edge on, `read_status` is 1.
- R6: While the window is open, each further 30h write adds its block and restarts a TIMEOUT_CYC-cycle timer. `erase_start` rises exactly TIMEOUT_CYC clock edges after the last accepted 30h write, with `erase_all`=0 and `erase_map` holding one bit per selected block.
- R7: Any write that does not fit the expected sequence returns the decoder to array-read mode without a start pulse. So does a write of F0h (low data byte) at any address, except in the program data slot, where F0h is taken as data.
- R8: While the engine is busy, all writes are ignored: no start pulse is issued and `read_status` stays 1 until `eng_done`.
- R9: `eng_done` without `eng_error` returns the decoder to array reads. `eng_done` with `eng_error` sets status bit 5 (the fail bit), and the decoder stays in status mode until an F0h write clears the fail bit and returns it to array reads. Status bit 3 is 1 while the block collection window is open. All other status bits are 0.
- R10: A write other than 30h during block collection abandons the erase: the decoder returns to array reads and no `erase_start` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| byte_mode | input | 1 | 1 = byte-mode unlock addresses, 0 = word mode |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data; command bytes in bits [7:0] |
| eng_done | input | 1 | Engine completion pulse |
| eng_error | input | 1 | Engine error, valid with eng_done |
| read_status | output | 1 | 1 = reads return status, 0 = array data |
| status_bits | output | 8 | Status byte: bit 5 fail, bit 3 window open |
| pgm_start | output | 1 | Program launch pulse |
| erase_start | output | 1 | Erase launch pulse |
| erase_all | output | 1 | Qualifies erase_start as chip erase |
| erase_map | output | NUM_BLOCKS | Selected blocks for block erase |
| op_addr | output | ADDR_W | Program target address |
| op_data | output | DATA_W | Program data |

## Verification
Programs are driven with random addresses and data, in both unlock modes. Prefix writes are broken at a random position, and random high address bits are used. This separates a correct low-bit-only address compare from the wrong mode's addresses and from an off-by-one launch position. Directed cases cover chip erase, single and two-block erase, and the exact cycle of the timeout-driven launch. They also cover abandoning a collection, F0h both as a reset and as program data, writes during busy, and a failed engine return followed by its clear. Each of these separates the sequence-tracking states from the launch and status logic.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
    typedef enum logic [3:0] {
        ST_ARRAY,
        ST_UNLK1,
        ST_UNLK2,
        ST_PGM_DATA,
        ST_ERS_ARM,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_BLK_COLLECT,
        ST_BUSY,
        ST_FAIL
    } dec_state_e;

    localparam logic [7:0] CMD_KEY_A   = 8'hAA;
    localparam logic [7:0] CMD_KEY_B   = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERS_SET = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_BLOCK   = 8'h30;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

    localparam int FAIL_BIT = 5;
    localparam int WIN_BIT  = 3;
endpackage

// File: rtl/nor_unlock_match.sv
module nor_unlock_match (
    input  logic        byte_mode,
    input  logic [11:0] addr_lo,
    output logic        hit_first,
    output logic        hit_second
);
    localparam logic [11:0] WORD_FIRST  = 12'h555;
    localparam logic [11:0] WORD_SECOND = 12'h2AA;
    localparam logic [11:0] BYTE_FIRST  = 12'hAAA;
    localparam logic [11:0] BYTE_SECOND = 12'h555;

    always_comb begin
        if (byte_mode) begin
            hit_first  = (addr_lo == BYTE_FIRST);
            hit_second = (addr_lo == BYTE_SECOND);
        end else begin
            hit_first  = (addr_lo == WORD_FIRST);
            hit_second = (addr_lo == WORD_SECOND);
        end
    end
endmodule

// File: rtl/nor_erase_timer.sv
module nor_erase_timer #(
    parameter int TIMEOUT_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic cancel,
    output logic expire,
    output logic window_open
);
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt <= '0;
        else if (restart)         cnt <= LOAD_VAL;
        else if (cancel)          cnt <= '0;
        else if (cnt != '0)       cnt <= cnt - LAST_VAL;
    end

    assign expire      = (cnt == LAST_VAL) && !restart;
    assign window_open = (cnt != '0);

    // R6: a restart can never be followed at once by expiry
    p_restart_no_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (window_open && !expire));
endmodule

// File: rtl/nor_block_map.sv
module nor_block_map #(
    parameter int NUM_BLOCKS = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          first,
    input  logic                          add,
    input  logic [$clog2(NUM_BLOCKS)-1:0] idx,
    output logic [NUM_BLOCKS-1:0]         map
);
    logic [NUM_BLOCKS-1:0] sel;

    always_comb begin
        sel = '0;
        sel[idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     map <= '0;
        else if (first) map <= sel;
        else if (add)   map <= map | sel;
    end

    // R6: a selected block is present in the map on the next cycle
    p_block_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (first || add) |=> map[$past(idx)]);
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int DATA_W      = 16,
    parameter int NUM_BLOCKS  = 128,
    parameter int TIMEOUT_CYC = 50
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  byte_mode,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  eng_done,
    input  logic                  eng_error,
    output logic                  read_status,
    output logic [7:0]            status_bits,
    output logic                  pgm_start,
    output logic                  erase_start,
    output logic                  erase_all,
    output logic [NUM_BLOCKS-1:0] erase_map,
    output logic [ADDR_W-1:0]     op_addr,
    output logic [DATA_W-1:0]     op_data
);
    localparam int IDX_W = $clog2(NUM_BLOCKS);

    dec_state_e state, nxt;
    logic       hit_first, hit_second;
    logic [7:0] cmd;
    logic       is_reset;
    logic       tmr_restart, tmr_cancel, tmr_expire, win_open;
    logic       map_first, map_add;
    logic       launch_pgm, launch_chip, launch_blk;
    logic       fail_q;

    assign cmd      = wr_data[7:0];
    assign is_reset = wr_en && (cmd == CMD_RESET);

    nor_unlock_match i_match (
        .byte_mode (byte_mode),
        .addr_lo   (wr_addr[11:0]),
        .hit_first (hit_first),
        .hit_second(hit_second)
    );

    nor_erase_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (tmr_restart),
        .cancel     (tmr_cancel),
        .expire     (tmr_expire),
        .window_open(win_open)
    );

    nor_block_map #(.NUM_BLOCKS(NUM_BLOCKS)) i_map (
        .clk  (clk),
        .rst_n(rst_n),
        .first(map_first),
        .add  (map_add),
        .idx  (wr_addr[ADDR_W-1 -: IDX_W]),
        .map  (erase_map)
    );

    // Next-state decode
    always_comb begin
        nxt         = state;
        tmr_restart = 1'b0;
        tmr_cancel  = 1'b0;
        map_first   = 1'b0;
        map_add     = 1'b0;
        launch_pgm  = 1'b0;
        launch_chip = 1'b0;
        launch_blk  = 1'b0;
        unique case (state)
            ST_ARRAY:
                if (wr_en && hit_first && cmd == CMD_KEY_A) nxt = ST_UNLK1;
            ST_UNLK1:
                if (wr_en) nxt = (hit_second && cmd == CMD_KEY_B) ? ST_UNLK2 : ST_ARRAY;
            ST_UNLK2:
                if (wr_en) begin
                    if (hit_first && cmd == CMD_PROGRAM)      nxt = ST_PGM_DATA;
                    else if (hit_first && cmd == CMD_ERS_SET) nxt = ST_ERS_ARM;
                    else                                      nxt = ST_ARRAY;
                end
            ST_PGM_DATA:
                if (wr_en) begin
                    nxt        = ST_BUSY;
                    launch_pgm = 1'b1;
                end
            ST_ERS_ARM:
                if (wr_en) nxt = (hit_first && cmd == CMD_KEY_A) ? ST_ERS_UNLK1 : ST_ARRAY;
            ST_ERS_UNLK1:
                if (wr_en) nxt = (hit_second && cmd == CMD_KEY_B) ? ST_ERS_UNLK2 : ST_ARRAY;
            ST_ERS_UNLK2:
                if (wr_en) begin
                    if (hit_first && cmd == CMD_CHIP) begin
                        nxt         = ST_BUSY;
                        launch_chip = 1'b1;
                    end else if (cmd == CMD_BLOCK) begin
                        nxt         = ST_BLK_COLLECT;
                        map_first   = 1'b1;
                        tmr_restart = 1'b1;
                    end else begin
                        nxt = ST_ARRAY;
                    end
                end
            ST_BLK_COLLECT:
                if (wr_en) begin
                    if (cmd == CMD_BLOCK) begin
                        map_add     = 1'b1;
                        tmr_restart = 1'b1;
                    end else begin
                        nxt        = ST_ARRAY;
                        tmr_cancel = 1'b1;
                    end
                end else if (tmr_expire) begin
                    nxt        = ST_BUSY;
                    launch_blk = 1'b1;
                end
            ST_BUSY:
                if (eng_done) nxt = eng_error ? ST_FAIL : ST_ARRAY;
            ST_FAIL:
                if (is_reset) nxt = ST_ARRAY;
            default: nxt = ST_ARRAY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_ARRAY;
        else        state <= nxt;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgm_start   <= 1'b0;
            erase_start <= 1'b0;
            erase_all   <= 1'b0;
            op_addr     <= '0;
            op_data     <= '0;
            fail_q      <= 1'b0;
        end else begin
            pgm_start   <= launch_pgm;
            erase_start <= launch_chip || launch_blk;
            if (launch_chip || launch_blk) erase_all <= launch_chip;
            if (launch_pgm) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
            if (state == ST_BUSY && eng_done && eng_error) fail_q <= 1'b1;
            else if (state == ST_FAIL && is_reset)         fail_q <= 1'b0;
        end
    end

    assign read_status = (state == ST_BLK_COLLECT) || (state == ST_BUSY) || (state == ST_FAIL);

    always_comb begin
        status_bits           = '0;
        status_bits[FAIL_BIT] = fail_q;
        status_bits[WIN_BIT]  = win_open;
    end

    // R8: at most one launch at a time
    p_single_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_start && erase_start));
    // R3: program launch is a one-cycle pulse
    p_pgm_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_start |=> !pgm_start);
    // R5: an erase in flight is always reported through status reads
    p_erase_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> read_status);
    // R6: a block erase never launches with an empty selection
    p_erase_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_start && !erase_all) |-> (erase_map != '0));
    // R8: the busy state is left only on engine completion
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !eng_done) |=> (state == ST_BUSY));
    // R9: the fail bit is only visible in status mode
    p_fail_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_bits[FAIL_BIT] |-> read_status);
endmodule

// File: tb/test_nor_cmd_decoder.sv
module test_nor_cmd_decoder;
    localparam int ADDR_W = 23;
    localparam int DATA_W = 16;
    localparam int NB     = 128;
    localparam int TO     = 50;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              byte_mode = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              eng_done = 1'b0;
    logic              eng_error = 1'b0;
    logic              read_status;
    logic [7:0]        status_bits;
    logic              pgm_start, erase_start, erase_all;
    logic [NB-1:0]     erase_map;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    nor_cmd_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BLOCKS(NB), .TIMEOUT_CYC(TO)) i_nor_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .eng_done(eng_done), .eng_error(eng_error),
        .read_status(read_status), .status_bits(status_bits), .pgm_start(pgm_start),
        .erase_start(erase_start), .erase_all(erase_all), .erase_map(erase_map),
        .op_addr(op_addr), .op_data(op_data)
    );

    function automatic logic [11:0] key1(input bit bm);
        return bm ? 12'hAAA : 12'h555;
    endfunction
    function automatic logic [11:0] key2(input bit bm);
        return bm ? 12'h555 : 12'h2AA;
    endfunction
    function automatic logic [ADDR_W-1:0] at(input logic [11:0] lo);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'($urandom);
        a[11:0] = lo;
        return a;
    endfunction
    function automatic logic [ADDR_W-1:0] blk_addr(input int b);
        logic [ADDR_W-1:0] a;
        a = ADDR_W'($urandom);
        a[ADDR_W-1 -: 7] = 7'(b);
        return a;
    endfunction
    // expected: program launches only if no prefix cycle (0..2) is corrupted
    function automatic bit exp_launch(input int brk);
        return brk > 2;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prefix(input bit bm);
        bus_wr(at(key1(bm)), 16'h00AA);
        bus_wr(at(key2(bm)), 16'h0055);
    endtask

    task automatic engine_finish(input bit err);
        eng_done = 1'b1; eng_error = err;
        @(posedge clk); @(negedge clk);
        eng_done = 1'b0; eng_error = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
        int k;
        bit seen;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(read_status == 0, "R1 read_status", read_status, 0);
        check(pgm_start == 0 && erase_start == 0, "R1 starts", {pgm_start, erase_start}, 0);
        check(status_bits == 0, "R1 status_bits", status_bits, 0);

        // R3/R2 word-mode program
        byte_mode = 0;
        prefix(0);
        bus_wr(at(12'h555), 16'h00A0);
        a = 23'h12_3456; d = 16'hBEEF;
        bus_wr(a, d);
        check(pgm_start == 1, "R3 pgm_start", pgm_start, 1);
        check(op_addr == a && op_data == d, "R3 op_addr/op_data", {op_addr, op_data}, {a, d});
        @(negedge clk);
        check(pgm_start == 0, "R3 pulse width", pgm_start, 0);
        // R8 writes while busy ignored
        bus_wr(at(12'h123), 16'h00F0);
        check(read_status == 1, "R8 F0 during busy", read_status, 1);
        prefix(0); bus_wr(at(12'h555), 16'h00A0);
        wr_en = 1; wr_addr = 23'h1; wr_data = 16'h1;
        @(posedge clk); @(negedge clk); wr_en = 0;
        check(pgm_start == 0, "R8 no launch while busy", pgm_start, 0);
        engine_finish(0);
        check(read_status == 0, "R9 done ok returns to array", read_status, 0);

        // R2 byte-mode program
        byte_mode = 1;
        prefix(1);
        bus_wr(at(12'hAAA), 16'h00A0);
        a = 23'h00_0ABC; d = 16'h0012;
        bus_wr(a, d);
        check(pgm_start == 1 && op_addr == a, "R2 byte-mode program", {pgm_start, op_addr}, {1'b1, a});
        engine_finish(0);
        // R2 word addresses in byte mode must not launch
        bus_wr(at(12'h555), 16'h00AA);
        bus_wr(at(12'h2AA), 16'h0055);
        bus_wr(at(12'h555), 16'h00A0);
        bus_wr(23'h7, 16'h0007);
        check(pgm_start == 0 && read_status == 0, "R2 wrong-mode addresses", {pgm_start, read_status}, 0);
        bus_wr(at(12'h0), 16'h00F0);

        // R7 F0 as program data is data; F0 in prefix is a reset
        byte_mode = 0;
        prefix(0); bus_wr(at(12'h555), 16'h00A0);
        bus_wr(23'h40, 16'h00F0);
        check(pgm_start == 1 && op_data == 16'h00F0, "R7 F0 as program data", {pgm_start, op_data}, {1'b1, 16'h00F0});
        engine_finish(0);
        prefix(0); bus_wr(at(12'h777), 16'h00F0);
        bus_wr(at(12'h555), 16'h00A0);
        bus_wr(23'h41, 16'h0001);
        check(pgm_start == 0 && read_status == 0, "R7 F0 resets sequence", {pgm_start, read_status}, 0);

        // R4 chip erase then R9 error path
        prefix(0); bus_wr(at(12'h555), 16'h0080); prefix(0);
        bus_wr(at(12'h555), 16'h0010);
        check(erase_start == 1 && erase_all == 1, "R4 chip erase launch", {erase_start, erase_all}, 2'b11);
        engine_finish(1);
        check(status_bits == 8'h20 && read_status == 1, "R9 fail bit set", {status_bits, read_status}, {8'h20, 1'b1});
        bus_wr(at(12'h555), 16'h00AA);
        check(read_status == 1, "R9 fail holds on non-reset write", read_status, 1);
        bus_wr(at(12'h321), 16'h00F0);
        check(read_status == 0 && status_bits == 0, "R9 F0 clears fail", {read_status, status_bits}, 0);

        // R5/R6 two-block erase with timer restart
        prefix(0); bus_wr(at(12'h555), 16'h0080); prefix(0);
        bus_wr(blk_addr(5), 16'h0030);
        check(read_status == 1, "R5 status after sixth write", read_status, 1);
        check(status_bits == 8'h08, "R9 window bit", status_bits, 8'h08);
        repeat (10) @(negedge clk);
        check(erase_start == 0, "R6 no early launch", erase_start, 0);
        bus_wr(blk_addr(9), 16'h0030);
        k = 0; seen = 0;
        while (!seen && k < TO + 10) begin
            @(posedge clk); @(negedge clk); k++;
            if (erase_start) seen = 1;
        end
        check(seen && k == TO, "R6 launch cycle", k, TO);
        check(erase_all == 0 && erase_map == ((NB'(1) << 5) | (NB'(1) << 9)), "R6 erase_map",
              erase_map, (NB'(1) << 5) | (NB'(1) << 9));
        engine_finish(0);

        // R10 abandon collection
        prefix(0); bus_wr(at(12'h555), 16'h0080); prefix(0);
        bus_wr(blk_addr(3), 16'h0030);
        bus_wr(23'h0, 16'h0000);
        check(read_status == 0, "R10 abandon returns to array", read_status, 0);
        seen = 0;
        for (int i = 0; i < TO + 5; i++) begin
            @(negedge clk);
            if (erase_start) seen = 1;
        end
        check(!seen, "R10 no erase after abandon", seen, 0);

        // R7/R2/R3 random programs with random break position
        for (int it = 0; it < 60; it++) begin
            bit bm;
            int brk;
            logic [7:0] pd [3];
            logic [11:0] pa [3];
            bm = 1'($urandom);
            byte_mode = bm;
            brk = int'($urandom_range(0, 5));
            pd[0] = 8'hAA; pd[1] = 8'h55; pd[2] = 8'hA0;
            pa[0] = key1(bm); pa[1] = key2(bm); pa[2] = key1(bm);
            for (int c = 0; c < 3; c++)
                bus_wr(at(pa[c]), {8'h00, (c == brk) ? (pd[c] ^ 8'h01) : pd[c]});
            a = ADDR_W'($urandom); d = DATA_W'($urandom);
            bus_wr(a, d);
            check(pgm_start == exp_launch(brk), "R7 random sequence launch", pgm_start, exp_launch(brk));
            if (exp_launch(brk)) begin
                check(op_addr == a && op_data == d, "R3 random op", {op_addr, op_data}, {a, d});
                engine_finish(0);
            end else begin
                bus_wr(at(12'h0), 16'h00F0);
            end
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule